// File: doc/BRIEF.md
# Bit-Serial Shift Address Offset Unit

This block sits between a bit-serial datapath's sequencer and its register file. The sequencer presents a word address and a bit index (0 to 17) for every bit time. In normal operation the block passes that pair through unchanged. When right-shift mode is on, the block points the read half of each bit time at the next bit up. It does this by adding one to the bit index, wrapping 17 to 0 and carrying into the word address. The write half still targets the original bit. Reading bit n+1 and writing bit n moves every bit down one place. On the top bit of the most significant word the offset is withheld, so the sign bit is copied onto itself and the shift is arithmetic.

The block also gates the register-file write enables. Moving the read address can change the address partway through a bit time. The block therefore opens the write enables only during the last quarter of the bit period, which is the second fast-clock cycle of the write half. The write then starts at least one quarter period after any possible address change. The register storage and the microcode sequencer are outside this block.

Top module: `sraddr_offset_unit`

## Requirements
- R1: While reset is held, and in the first cycle after reset release, every gated write enable is 0, even with all raw enables high and the phase in its write half.
- R2: With shift enabled and the phase in its read half (rd_phase_i=1), a bit index k in 0..16 gives addr_o bit field (bits 4:0) = k+1 and word field (upper bits) = the input word.
- R3: With shift enabled in the read half, bit index 17 outside the most significant word gives bit field 0 and word field = input word + 1, modulo 2^WORD_W.
- R4: With shift enabled in the read half, bit index 17 with msw_i=1 gives addr_o equal to the unmodified input word and bit.
- R5: With shift disabled, addr_o equals the input word and bit in either half.
- R6: In the write half (rd_phase_i=0), addr_o equals the input word and bit whatever shift_en_i and msw_i are.
- R7: Gated write enables are 0 throughout the read half and in the first cycle of the write half. In the second cycle of the write half they follow the raw enables bit for bit.
- R8: A raw write enable that is 0 keeps its gated output at 0, including during the last quarter.
- R9: msw_i has no effect for bit indexes other than 17; the offset still applies to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, HALF_CYC cycles per half bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | WORD_W | Word address from the sequencer |
| bit_i | input | 5 | Bit index within the word, 0..17 |
| shift_en_i | input | 1 | Right-shift mode enable |
| rd_phase_i | input | 1 | 1 during the read half of the bit time, 0 during the write half |
| msw_i | input | 1 | Current word is the most significant word |
| we_raw_i | input | NUM_WE | Raw register-file write enables |
| addr_o | output | WORD_W+5 | Effective address: {word, bit} |
| we_o | output | NUM_WE | Write enables gated to the last quarter |

## Verification
Some properties are checked by assertions on every cycle:
- Gated enables never appear during the read half.
- Gated enables never appear before the write half has lasted one full cycle, and never without their raw enable.
- The address is passed through in the write half.
- The sign bit is held in place on the most significant word.

The bench's scenarios are needed to show the exact offset values: the increment for low indexes, the wrap from 17 to 0 with a carry into the word field (including the roll-over of the word field itself), and that msw_i is ignored away from bit 17. The reset behaviour and the cycle in which the enables open are also shown by the scenarios.

// File: rtl/sraddr_pkg.sv
package sraddr_pkg;

    // Width of the bit-index field and number of bits held in one word.
    localparam int unsigned BIT_W         = 5;
    localparam int unsigned BITS_PER_WORD = 18;

    typedef logic [BIT_W-1:0] bit_idx_t;

endpackage

// File: rtl/sraddr_bit_inc.sv
module sraddr_bit_inc
    import sraddr_pkg::*;
#(
    parameter int unsigned WORD_W   = 4,
    parameter int unsigned LAST_BIT = BITS_PER_WORD - 1
) (
    input  logic              inc_i,
    input  logic [WORD_W-1:0] word_i,
    input  bit_idx_t          bit_i,
    output logic [WORD_W-1:0] word_o,
    output bit_idx_t          bit_o
);

    localparam int unsigned SUM_W = BIT_W + 1;

    logic [SUM_W-1:0] sum;
    logic             carry;

    // One-bit increment with wrap past the last bit of a word.
    always_comb begin
        sum    = SUM_W'(bit_i) + SUM_W'(1);
        carry  = 1'b0;
        bit_o  = bit_i;
        if (inc_i) begin
            if (sum == SUM_W'(LAST_BIT + 1)) begin
                bit_o = '0;
                carry = 1'b1;
            end else begin
                bit_o = sum[BIT_W-1:0];
            end
        end
        word_o = word_i + WORD_W'(carry);
    end

endmodule

// File: rtl/sraddr_wr_timer.sv
module sraddr_wr_timer #(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_phase_i,
    output logic twrite_o
);

    // Write window opens halfway through the write half.
    localparam int unsigned LATE_START = HALF_CYC / 2;
    localparam int unsigned CNT_W      = $clog2(LATE_START + 1);

    generate
        if ((HALF_CYC < 2) || (HALF_CYC % 2 != 0)) begin : g_bad_half
            $error("HALF_CYC must be an even value of at least 2");
        end
    endgenerate

    typedef struct packed {
        logic [CNT_W-1:0] low_cnt;
    } tmr_state_t;

    tmr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rd_phase_i) begin
            state_d.low_cnt = '0;
        end else if (state_q.low_cnt != CNT_W'(LATE_START)) begin
            state_d.low_cnt = state_q.low_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign twrite_o = !rd_phase_i && (state_q.low_cnt == CNT_W'(LATE_START));

    // R7: the window only opens after the write half has run at least one cycle
    a_r7_window_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        twrite_o |-> !$past(rd_phase_i));

    // R7: never open during the read half
    a_r7_window_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase_i |-> !twrite_o);

endmodule

// File: rtl/sraddr_offset_unit.sv
module sraddr_offset_unit
    import sraddr_pkg::*;
#(
    parameter int unsigned WORD_W   = 4,
    parameter int unsigned NUM_WE   = 3,
    parameter int unsigned HALF_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       word_i,
    input  logic [BIT_W-1:0]        bit_i,
    input  logic                    shift_en_i,
    input  logic                    rd_phase_i,
    input  logic                    msw_i,
    input  logic [NUM_WE-1:0]       we_raw_i,
    output logic [WORD_W+BIT_W-1:0] addr_o,
    output logic [NUM_WE-1:0]       we_o
);

    localparam int unsigned LAST_BIT = BITS_PER_WORD - 1;

    logic              sign_bit;
    logic              inc_req;
    logic              twrite;
    logic [WORD_W-1:0] word_eff;
    bit_idx_t          bit_eff;

    // Offset only in the read half, and never on the sign bit.
    assign sign_bit = msw_i && (bit_i == BIT_W'(LAST_BIT));
    assign inc_req  = shift_en_i && rd_phase_i && !sign_bit;

    sraddr_bit_inc #(
        .WORD_W   (WORD_W),
        .LAST_BIT (LAST_BIT)
    ) u_inc (
        .inc_i  (inc_req),
        .word_i (word_i),
        .bit_i  (bit_i),
        .word_o (word_eff),
        .bit_o  (bit_eff)
    );

    sraddr_wr_timer #(
        .HALF_CYC (HALF_CYC)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_phase_i (rd_phase_i),
        .twrite_o   (twrite)
    );

    assign addr_o = {word_eff, bit_eff};

    generate
        for (genvar g = 0; g < NUM_WE; g++) begin : g_we_gate
            assign we_o[g] = we_raw_i[g] && twrite;
        end
    endgenerate

    // R6: write half sees the plain address
    a_r6_write_plain: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_phase_i |-> (addr_o == {word_i, bit_i}));

    // R4: sign bit of the top word is read in place
    a_r4_sign_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sign_bit |-> (addr_o == {word_i, bit_i}));

    // R8: no gated enable without its raw enable
    a_r8_we_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((we_o & ~we_raw_i) == '0));

    // R7: gated enables stay low in the read half
    a_r7_we_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase_i |-> (we_o == '0));

endmodule

// File: tb/sraddr_offset_unit_tb.sv
module sraddr_offset_unit_tb;

    localparam int WORD_W = 4;
    localparam int NUM_WE = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] word_i = '0;
    logic [4:0]        bit_i = '0;
    logic              shift_en_i = 1'b0;
    logic              rd_phase_i = 1'b0;
    logic              msw_i = 1'b0;
    logic [NUM_WE-1:0] we_raw_i = '0;
    logic [WORD_W+4:0] addr_o;
    logic [NUM_WE-1:0] we_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sraddr_offset_unit #(.WORD_W(WORD_W), .NUM_WE(NUM_WE), .HALF_CYC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .bit_i(bit_i),
        .shift_en_i(shift_en_i), .rd_phase_i(rd_phase_i), .msw_i(msw_i),
        .we_raw_i(we_raw_i), .addr_o(addr_o), .we_o(we_o)
    );

    // Vector: word, bit, shift, rd, msw, exp word, exp bit
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {4'd3,  5'd0,  1'b1, 1'b1, 1'b0, 4'd3,  5'd1 },  // R2
        {4'd3,  5'd16, 1'b1, 1'b1, 1'b0, 4'd3,  5'd17},  // R2
        {4'd3,  5'd17, 1'b1, 1'b1, 1'b0, 4'd4,  5'd0 },  // R3
        {4'd15, 5'd17, 1'b1, 1'b1, 1'b0, 4'd0,  5'd0 },  // R3 word roll-over
        {4'd7,  5'd17, 1'b1, 1'b1, 1'b1, 4'd7,  5'd17},  // R4
        {4'd7,  5'd17, 1'b1, 1'b0, 1'b1, 4'd7,  5'd17},  // R6
        {4'd2,  5'd9,  1'b0, 1'b1, 1'b0, 4'd2,  5'd9 },  // R5
        {4'd2,  5'd9,  1'b1, 1'b0, 1'b0, 4'd2,  5'd9 },  // R6
        {4'd9,  5'd5,  1'b1, 1'b1, 1'b1, 4'd9,  5'd6 },  // R9
        {4'd0,  5'd17, 1'b0, 1'b1, 1'b0, 4'd0,  5'd17}   // R5
    };
    localparam string VTAG [NV] = '{"R2","R2","R3","R3","R4","R6","R5","R6","R9","R5"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset holds enables low
        rd_phase_i = 1'b0;
        we_raw_i   = 3'b111;
        repeat (3) @(negedge clk);
        #2 check("R1 in reset", 32'(we_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #2 check("R1 first cycle after reset", 32'(we_o), 32'd0);
        @(negedge clk);
        #2 check("R7 late quarter follows raw", 32'(we_o), 32'b111);

        // R7: read half closed, first write cycle closed, second open
        @(negedge clk); rd_phase_i = 1'b1; we_raw_i = 3'b101;
        #2 check("R7 read cycle 0", 32'(we_o), 32'd0);
        @(negedge clk);
        #2 check("R7 read cycle 1", 32'(we_o), 32'd0);
        @(negedge clk); rd_phase_i = 1'b0;
        #2 check("R7 write cycle 0", 32'(we_o), 32'd0);
        @(negedge clk);
        #2 check("R7 write cycle 1", 32'(we_o), 32'b101);

        // R8: raw enables off during the open window
        @(negedge clk); rd_phase_i = 1'b1; we_raw_i = 3'b000;
        @(negedge clk);
        @(negedge clk); rd_phase_i = 1'b0;
        @(negedge clk);
        #2 check("R8 raw off in window", 32'(we_o), 32'd0);
        we_raw_i = 3'b010;
        #1 check("R8 single raw enable", 32'(we_o), 32'b010);

        // Address vectors
        @(negedge clk); we_raw_i = '0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {word_i, bit_i, shift_en_i, rd_phase_i, msw_i} = VEC[i][20:9];
            #2 check(VTAG[i], 32'(addr_o), 32'(VEC[i][8:0]));
        end

        // R9: msw with a low index still offsets in read half
        @(negedge clk);
        word_i = 4'd1; bit_i = 5'd16; shift_en_i = 1'b1; rd_phase_i = 1'b1; msw_i = 1'b1;
        #2 check("R9 msw bit 16", 32'(addr_o), 32'({4'd1, 5'd17}));

        @(negedge clk);
        finish_run();
    end

endmodule